// File: doc/BRIEF.md
# Divided Countdown Timer with Modes

This block is a local countdown timer for one processing element. A free-running prescaler divides the clock by a power of two that a small divide setting selects. A count register counts down once per prescaler tick from a value that software writes. When the count expires the timer either stops at zero (one-shot) or reloads and carries on (periodic). Each expiry adds one to a saturating pending-event counter.

A single table entry governs delivery. It holds a mask bit, a periodic bit and an interrupt vector. While the entry is unmasked and at least one event is pending, the block offers an interrupt request on a valid/ready port. The request carries the entry's vector and stands for fixed, edge-triggered delivery. Each accepted request (valid and ready high in the same cycle) removes one pending event. A consumer may hold ready low for as long as it needs. The request then stays up with a steady vector until it is accepted or a register write changes the state that feeds it.

A software enable bit protects the entry. While the bit is clear, every write to the entry stores the mask bit as 1. Clearing the bit also masks the entry and discards all pending events. All registers are written through one plain write port, and the current count, the pending count and the entry flags are brought out for observation.

Top module: `cdt_top`

## Requirements
- R1: The divide setting is written with wr_sel=2 and taken from wr_data[3:0]. Bits 3, 1 and 0 are read as a 3-bit number e = ({b3,b1,b0}+1) mod 8, bit 2 is ignored, and the count decrements once every 2^e clock cycles (1011 divides by 1, 0001 by 4, 1010 by 128, 0100 and 0000 by 2). The prescaler restarts from zero on each initial-count write.
- R2: A write with wr_sel=3 stores wr_data as the initial count. The current count takes that value at the next clock edge and any countdown in progress is abandoned. The same write clears the pending counter.
- R3: With an initial count of 0 the timer is stopped: the current count reads 0 and no expiry occurs.
- R4: In one-shot mode (entry bit 9 = 0) the tick that would take the count from 1 to 0 is an expiry. The count then stays at 0 until the next initial-count write.
- R5: In periodic mode (entry bit 9 = 1) an expiry reloads the count from the initial count instead of 0, so expiries recur every initial-count times divisor cycles.
- R6: Each expiry adds one to the pending counter, which holds at 2^PEND_W-1 (15 by default) rather than wrapping.
- R7: irq_valid is high exactly when the entry mask (bit 8) is 0 and pending is nonzero, and irq_vector equals the entry vector (bits 7:0). An accepted request decrements pending. An expiry and an acceptance in the same cycle leave pending unchanged. Pending never goes below 0, and ready has no effect while the entry is masked.
- R8: While irq_valid is high and irq_ready is low, and no register is written, irq_valid stays high and irq_vector stays unchanged on the next cycle.
- R9: An entry write (wr_sel=1) made while the software enable is clear stores the mask bit as 1 whatever wr_data[8] holds.
- R10: Writing the software enable (wr_sel=0, wr_data[0]) with 0 sets the entry mask and clears the pending counter at the next edge.
- R11: After reset the entry is masked and one-shot, the current count and pending are 0, no request is offered, the software enable is clear, the divide setting is 0 (divide by 2) and the initial count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 enable, 1 entry, 2 divide, 3 initial count |
| wr_data | input | DATA_W | Write data |
| cur_count | output | CNT_W | Current count |
| pend_count | output | PEND_W | Pending expiry events |
| entry_mask | output | 1 | Stored entry mask bit |
| entry_periodic | output | 1 | Stored entry periodic bit |
| irq_valid | output | 1 | Interrupt request offered |
| irq_ready | input | 1 | Consumer accepts the request |
| irq_vector | output | VEC_W | Vector carried by the request |

## Verification
The pending counter can see an expiry and an acceptance in the same cycle. The bench provokes this with a periodic initial count of 1 at divide-by-1, which expires on every edge, and holds ready high once several events are pending. The counter is expected to keep its value over consecutive edges instead of stepping. A second clash pairs an expiry with a clearing write (software disable or a new initial count) at the same edge, and the clear is judged to win because pending reads 0 right after the write.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // register select codes on wr_sel
  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_ENTRY  = 2'd1,
    SEL_DIVIDE = 2'd2,
    SEL_INIT   = 2'd3
  } cdt_sel_e;

  // entry field positions inside wr_data
  localparam int ENTRY_MASK_BIT = 8;
  localparam int ENTRY_PER_BIT  = 9;
  localparam int DIV_CFG_W      = 4;
  localparam int EXP_W          = 3;
  localparam int PRE_W          = (1 << EXP_W) - 1;
endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale
  import cdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             tick
);
  logic [PRE_W-1:0] presc;
  logic [PRE_W-1:0] low_mask;

  // bits below the exponent must all be ones for a tick
  always_comb begin
    for (int i = 0; i < PRE_W; i++) low_mask[i] = (i < int'(exp_sel));
  end

  assign tick = &(presc | ~low_mask);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) presc <= '0;
    else                   presc <= presc + 1'b1;
  end
endmodule

// File: rtl/cdt_count.sv
module cdt_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic active;
  assign active = (cur != '0);
  assign expire = !load && tick && (cur == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)                cur <= '0;
    else if (load)             cur <= load_val;
    else if (tick && active) begin
      if (cur == ONE)          cur <= periodic ? reload_val : '0;
      else                     cur <= cur - ONE;
    end
  end
endmodule

// File: rtl/cdt_pending.sv
module cdt_pending #(
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              inc,
  input  logic              dec,
  output logic [PEND_W-1:0] cnt
);
  localparam logic [PEND_W-1:0] TOP = {PEND_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else begin
      unique case ({inc, dec})
        2'b10:   if (cnt != TOP) cnt <= cnt + 1'b1;
        2'b01:   if (cnt != '0)  cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/cdt_top.sv
module cdt_top
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int VEC_W  = 8,
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  cur_count,
  output logic [PEND_W-1:0] pend_count,
  output logic              entry_mask,
  output logic              entry_periodic,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [VEC_W-1:0]  irq_vector
);
  logic                 sw_en;
  logic [VEC_W-1:0]     vec_q;
  logic [DIV_CFG_W-1:0] div_cfg;
  logic [CNT_W-1:0]     init_q;
  logic [EXP_W-1:0]     exp_sel;
  logic                 tick, expire, accept;
  logic                 wr_init, wr_entry, wr_div, sw_off, pend_clr;

  assign wr_init  = wr_en && (wr_sel == SEL_INIT);
  assign wr_entry = wr_en && (wr_sel == SEL_ENTRY);
  assign wr_div   = wr_en && (wr_sel == SEL_DIVIDE);
  assign sw_off   = wr_en && (wr_sel == SEL_ENABLE) && !wr_data[0];
  assign pend_clr = wr_init || sw_off;

  // bit 2 of the divide setting takes no part in the exponent
  assign exp_sel = {div_cfg[3], div_cfg[1], div_cfg[0]} + 3'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_en          <= 1'b0;
      entry_mask     <= 1'b1;
      entry_periodic <= 1'b0;
      vec_q          <= '0;
      div_cfg        <= '0;
      init_q         <= '0;
    end else if (wr_en) begin
      unique case (wr_sel)
        SEL_ENABLE: begin
          sw_en <= wr_data[0];
          if (!wr_data[0]) entry_mask <= 1'b1;
        end
        SEL_ENTRY: begin
          entry_mask     <= wr_data[ENTRY_MASK_BIT] | ~sw_en;
          entry_periodic <= wr_data[ENTRY_PER_BIT];
          vec_q          <= wr_data[VEC_W-1:0];
        end
        SEL_DIVIDE: div_cfg <= wr_data[DIV_CFG_W-1:0];
        default:    init_q  <= wr_data[CNT_W-1:0];
      endcase
    end
  end

  cdt_prescale u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_init),
    .exp_sel (exp_sel),
    .tick    (tick)
  );

  cdt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (wr_init),
    .load_val   (wr_data[CNT_W-1:0]),
    .reload_val (init_q),
    .tick       (tick),
    .periodic   (entry_periodic),
    .cur        (cur_count),
    .expire     (expire)
  );

  assign irq_valid  = !entry_mask && (pend_count != '0);
  assign irq_vector = vec_q;
  assign accept     = irq_valid && irq_ready;

  cdt_pending #(.PEND_W(PEND_W)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (pend_clr),
    .inc   (expire),
    .dec   (accept),
    .cnt   (pend_count)
  );
endmodule

// File: rtl/cdt_chk.sv
module cdt_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int VEC_W  = 8,
  parameter int PEND_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  cur_count,
  input logic [PEND_W-1:0] pend_count,
  input logic              entry_mask,
  input logic              irq_valid,
  input logic              irq_ready,
  input logic [VEC_W-1:0]  irq_vector,
  input logic              sw_en,
  input logic              expire
);
  localparam logic [PEND_W-1:0] TOP = {PEND_W{1'b1}};
  logic clr_in;
  assign clr_in = wr_en && (wr_sel == 2'd3 || (wr_sel == 2'd0 && !wr_data[0]));

  // R2
  init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> (cur_count == $past(wr_data[CNT_W-1:0]) && pend_count == '0));

  // R4
  zero_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_count == '0 && !(wr_en && wr_sel == 2'd3)) |=> (cur_count == '0));

  // R6
  pend_hold_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_count == TOP && !(irq_valid && irq_ready) && !clr_in) |=> (pend_count == TOP));

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_count == '0 && !expire) |=> (pend_count == '0));

  // R8
  hold_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready && !wr_en) |=> (irq_valid && $stable(irq_vector)));

  // R9
  forced_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1 && !sw_en) |=> entry_mask);

  // R10
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && !wr_data[0]) |=> (entry_mask && pend_count == '0));
endmodule

bind cdt_top cdt_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .VEC_W(VEC_W), .PEND_W(PEND_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .cur_count  (cur_count),
  .pend_count (pend_count),
  .entry_mask (entry_mask),
  .irq_valid  (irq_valid),
  .irq_ready  (irq_ready),
  .irq_vector (irq_vector),
  .sw_en      (sw_en),
  .expire     (expire)
);

// File: tb/tb_cdt_top.sv
module tb_cdt_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] cur_count;
  logic [3:0]  pend_count;
  logic        entry_mask, entry_periodic, irq_valid;
  logic        irq_ready = 1'b0;
  logic [7:0]  irq_vector;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cdt_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cur_count(cur_count), .pend_count(pend_count), .entry_mask(entry_mask),
    .entry_periodic(entry_periodic), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_vector(irq_vector)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R11 mask", {31'd0, entry_mask}, 32'd1);
    check("R11 periodic", {31'd0, entry_periodic}, 32'd0);
    check("R11 count", cur_count, 32'd0);
    check("R11 pending", {28'd0, pend_count}, 32'd0);
    check("R11 valid", {31'd0, irq_valid}, 32'd0);
  endtask

  task automatic t_default_div;
    wr(2'd3, 32'd3);
    check("R2 load", cur_count, 32'd3);
    step(5);
    check("R1 R11 div2 count", cur_count, 32'd1);
    step(1);
    check("R4 expire count", cur_count, 32'd0);
    check("R6 pending one", {28'd0, pend_count}, 32'd1);
    check("R7 masked no valid", {31'd0, irq_valid}, 32'd0);
    step(4);
    check("R4 stays zero", cur_count, 32'd0);
  endtask

  task automatic t_div_decode;
    wr(2'd2, 32'hB); wr(2'd3, 32'd3);
    step(2); check("R1 div1 pre", cur_count, 32'd1);
    step(1); check("R1 div1 expire", cur_count, 32'd0);
    wr(2'd2, 32'h1); wr(2'd3, 32'd2);
    step(7); check("R1 div4 pre", cur_count, 32'd1);
    step(1); check("R1 div4 expire", cur_count, 32'd0);
    wr(2'd2, 32'hA); wr(2'd3, 32'd2);
    step(255); check("R1 div128 pre", cur_count, 32'd1);
    step(1); check("R1 div128 expire", cur_count, 32'd0);
    wr(2'd2, 32'h4); wr(2'd3, 32'd1);
    step(1); check("R1 bit2 ignored pre", cur_count, 32'd1);
    step(1); check("R1 bit2 ignored expire", cur_count, 32'd0);
  endtask

  task automatic t_periodic;
    wr(2'd2, 32'hB);
    wr(2'd0, 32'd1);
    wr(2'd1, (32'd1 << 9) | (32'd1 << 8) | 32'h42);
    wr(2'd3, 32'd5);
    step(4); check("R5 before reload", cur_count, 32'd1);
    step(1); check("R5 reload", cur_count, 32'd5);
    check("R6 pending one", {28'd0, pend_count}, 32'd1);
    step(5); check("R5 second reload", cur_count, 32'd5);
    check("R6 pending two", {28'd0, pend_count}, 32'd2);
    step(2); check("R2 mid count", cur_count, 32'd3);
    wr(2'd3, 32'd10);
    check("R2 restart", cur_count, 32'd10);
    check("R2 pending cleared", {28'd0, pend_count}, 32'd0);
  endtask

  task automatic t_zero;
    wr(2'd3, 32'd0);
    check("R3 reads zero", cur_count, 32'd0);
    step(20);
    check("R3 still zero", cur_count, 32'd0);
    check("R3 no expiry", {28'd0, pend_count}, 32'd0);
  endtask

  task automatic t_irq;
    wr(2'd1, (32'd1 << 9) | 32'h5A);
    wr(2'd3, 32'd4);
    step(3); check("R7 no valid yet", {31'd0, irq_valid}, 32'd0);
    step(1); check("R7 valid", {31'd0, irq_valid}, 32'd1);
    check("R7 vector", {24'd0, irq_vector}, 32'h5A);
    step(2); check("R8 held valid", {31'd0, irq_valid}, 32'd1);
    check("R8 held vector", {24'd0, irq_vector}, 32'h5A);
    irq_ready = 1'b1;
    step(1); check("R7 accepted", {28'd0, pend_count}, 32'd0);
    check("R7 valid drops", {31'd0, irq_valid}, 32'd0);
    step(1); check("R7 no underflow", {28'd0, pend_count}, 32'd1);
    irq_ready = 1'b0;
  endtask

  task automatic t_same_cycle;
    wr(2'd3, 32'd1);
    step(3); check("R6 three pending", {28'd0, pend_count}, 32'd3);
    irq_ready = 1'b1;
    step(2); check("R7 expire+accept", {28'd0, pend_count}, 32'd3);
    irq_ready = 1'b0;
  endtask

  task automatic t_saturate;
    wr(2'd1, (32'd1 << 9) | (32'd1 << 8) | 32'h5A);
    step(20); check("R6 saturated", {28'd0, pend_count}, 32'd15);
    irq_ready = 1'b1;
    step(3); check("R7 masked ignores ready", {28'd0, pend_count}, 32'd15);
    irq_ready = 1'b0;
  endtask

  task automatic t_disable;
    wr(2'd1, (32'd1 << 9) | 32'h5A);
    check("R7 unmasked valid", {31'd0, irq_valid}, 32'd1);
    wr(2'd0, 32'd0);
    check("R10 mask set", {31'd0, entry_mask}, 32'd1);
    check("R10 pending cleared", {28'd0, pend_count}, 32'd0);
    wr(2'd1, 32'h5A);
    check("R9 forced mask", {31'd0, entry_mask}, 32'd1);
    wr(2'd3, 32'd0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_default_div();
    t_div_decode();
    t_periodic();
    t_zero();
    t_irq();
    t_same_cycle();
    t_saturate();
    t_disable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule